// File: doc/BRIEF.md
# USB Host Port Power-State Controller

This block sequences the low-power states of a single USB host port. Software drives it through single-cycle request strobes for suspend, resume and reset, plus a level that enables remote wakeup. The bus side supplies line-state levels for idle, K-state, connect and "all devices disconnected", and another agent may pulse an external wake strobe. From these inputs the controller drives a transceiver clock enable, a traffic-block signal, a forced bus-idle signal, resume and reset signalling requests, a suspend status bit, and a sticky interrupt with a cause field.

There are two suspend paths. Ordinary suspend first holds the bus idle for a fixed number of milliseconds and then gates the clock. It can be left through remote wakeup, an external wake, or a software resume or reset. Disconnect suspend gates the clock at once. It can be left only through a reset from software, and a connect event wakes it up to wait for that reset. All intervals are counted in ticks of a 1 ms input strobe. The interval counter reloads whenever a state is entered, so a tick that arrives early never shortens an interval.

Top module: `usb_port_pwr`

## Requirements
- R1: After reset the port is operational (port_state 0). xcvr_clk_en is 1. traffic_block, bus_idle_force, resume_drive, reset_drive, susp_bit and irq are 0, and irq_cause is 3'b000.
- R2: A sw_suspend pulse in the operational state with line_disconnect low enters idle-wait (state 1). In idle-wait, bus_idle_force, traffic_block and susp_bit are 1 and the clock stays on. After IDLE_MS (3) ticks of uninterrupted line_idle counted from entry, the port enters suspend (state 2) with xcvr_clk_en 0. Any cycle with line_idle low restarts the count.
- R3: In suspend with rwake_en high, line_k enters remote-wake resume (state 3). There xcvr_clk_en and resume_drive are 1, susp_bit is 0 and irq_cause bit 0 is set.
- R4: Remote-wake resume returns to the operational state on the RESUME_MS (20)th tick after entry. A tick in the entry cycle is not counted.
- R5: In suspend with rwake_en low, line_k is ignored. The state stays 2, the clock stays off and no interrupt is raised.
- R6: ext_wake in suspend enters awake-hold (state 4). There xcvr_clk_en is 1, susp_bit is 0, traffic_block is 1 and irq_cause bit 2 is set.
- R7: sw_resume in suspend or awake-hold enters software resume (state 5) with resume_drive 1. The port returns to state 0 on the RESUME_MS (20)th tick after entry.
- R8: sw_reset in suspend, awake-hold, disconnect-suspend or connect-wait enters bus reset (state 6) with reset_drive 1. The port returns to state 0 after RESET_MS (10) ticks. sw_reset wins over sw_resume in the same cycle. In suspend the order of precedence is reset, resume, ext_wake, line_k.
- R9: A sw_suspend pulse in the operational state with line_disconnect high enters disconnect-suspend (state 7) at once. There the clock is off and traffic_block, bus_idle_force and susp_bit are 1.
- R10: line_connect in disconnect-suspend enters connect-wait (state 8). There the clock is on and irq_cause bit 1 is set. The port stays in state 8 through sw_resume until sw_reset arrives.
- R11: irq is the OR of irq_cause. Each cause bit holds until irq_clr has a 1 in its position. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| sw_suspend | input | 1 | Software suspend request strobe |
| sw_resume | input | 1 | Software resume request strobe |
| sw_reset | input | 1 | Software port reset request strobe |
| rwake_en | input | 1 | Remote wakeup enable level |
| irq_clr | input | 3 | Write-one-to-clear strobes for the cause bits |
| line_idle | input | 1 | Bus is in the idle state |
| line_k | input | 1 | Bus shows a K-state |
| line_connect | input | 1 | Connect detected |
| line_disconnect | input | 1 | All devices are disconnected |
| ext_wake | input | 1 | External wake strobe |
| xcvr_clk_en | output | 1 | Transceiver clock enable |
| traffic_block | output | 1 | Blocks all port traffic |
| bus_idle_force | output | 1 | Forces idle on the bus |
| resume_drive | output | 1 | Requests resume signalling |
| reset_drive | output | 1 | Requests bus reset signalling |
| susp_bit | output | 1 | Suspend status bit |
| irq | output | 1 | Interrupt, OR of the causes |
| irq_cause | output | 3 | Sticky causes: bit0 remote wake, bit1 connect, bit2 external wake |
| port_state | output | 4 | Current state code |

## Verification
A wrong state decode shows up on port_state and the five control outputs in the cycle after the edge that caused it. A miscounted interval shows up only at the tick where the exit should have happened, so the bench counts the ticks around each exit and checks both the tick before it and the tick that ends it. A lost or misprioritised cause bit stays visible on irq_cause until the next clear, so mixed random pulses against a bench model expose it within a few cycles.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [3:0] {
        PS_OPER     = 4'd0,
        PS_IDLEWAIT = 4'd1,
        PS_SUSP     = 4'd2,
        PS_RWAKE    = 4'd3,
        PS_XWAKE    = 4'd4,
        PS_RESUME   = 4'd5,
        PS_RESET    = 4'd6,
        PS_DSUSP    = 4'd7,
        PS_DCONN    = 4'd8
    } pstate_e;

    localparam int CAUSE_W     = 3;
    localparam int CAUSE_RWAKE = 0;
    localparam int CAUSE_CONN  = 1;
    localparam int CAUSE_XWAKE = 2;

    typedef struct packed {
        pstate_e st;
        logic    susp;
    } fsm_t;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int MAX_VAL = 20,
    localparam int CW = $clog2(MAX_VAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = tick && (cnt_q == CW'(1));

    // R4: the count never exceeds the longest interval
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_VAL));
    // R4: a reload takes effect on the next edge, ticks notwithstanding
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/pps_irq.sv
module pps_irq #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cause,
    output logic         irq
);
    logic [W-1:0] cause_d, cause_q;

    always_comb begin
        cause_d = (cause_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause = cause_q;
    assign irq   = |cause_q;

    for (genvar i = 0; i < W; i++) begin : g_sticky
        // R11: a cause bit holds unless cleared
        assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (cause_q[i] && !clr[i]) |=> cause_q[i]);
        // R11: a set beats a simultaneous clear
        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> cause_q[i]);
    end
endmodule

// File: rtl/usb_port_pwr.sv
module usb_port_pwr
    import pps_pkg::*;
#(
    parameter int IDLE_MS   = 3,
    parameter int RESUME_MS = 20,
    parameter int RESET_MS  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic                sw_suspend,
    input  logic                sw_resume,
    input  logic                sw_reset,
    input  logic                rwake_en,
    input  logic [CAUSE_W-1:0]  irq_clr,
    input  logic                line_idle,
    input  logic                line_k,
    input  logic                line_connect,
    input  logic                line_disconnect,
    input  logic                ext_wake,
    output logic                xcvr_clk_en,
    output logic                traffic_block,
    output logic                bus_idle_force,
    output logic                resume_drive,
    output logic                reset_drive,
    output logic                susp_bit,
    output logic                irq,
    output logic [CAUSE_W-1:0]  irq_cause,
    output logic [3:0]          port_state
);
    localparam int MAXA = (IDLE_MS > RESUME_MS) ? IDLE_MS : RESUME_MS;
    localparam int MAXV = (MAXA > RESET_MS) ? MAXA : RESET_MS;
    localparam int CW   = $clog2(MAXV + 1);

    fsm_t               r_q, r_d;
    logic               t_load, t_done;
    logic [CW-1:0]      t_val;
    logic [CAUSE_W-1:0] c_set;

    function automatic logic [CW-1:0] interval_of(input pstate_e s);
        case (s)
            PS_IDLEWAIT:         return CW'(IDLE_MS);
            PS_RWAKE, PS_RESUME: return CW'(RESUME_MS);
            PS_RESET:            return CW'(RESET_MS);
            default:             return '0;
        endcase
    endfunction

    always_comb begin
        r_d    = r_q;
        c_set  = '0;
        t_load = 1'b0;
        case (r_q.st)
            PS_OPER:
                if (sw_suspend) r_d.st = line_disconnect ? PS_DSUSP : PS_IDLEWAIT;
            PS_IDLEWAIT:
                if (!line_idle)  t_load = 1'b1;
                else if (t_done) r_d.st = PS_SUSP;
            PS_SUSP:
                if (sw_reset)       r_d.st = PS_RESET;
                else if (sw_resume) r_d.st = PS_RESUME;
                else if (ext_wake) begin
                    r_d.st = PS_XWAKE;
                    c_set[CAUSE_XWAKE] = 1'b1;
                end else if (line_k && rwake_en) begin
                    r_d.st = PS_RWAKE;
                    c_set[CAUSE_RWAKE] = 1'b1;
                end
            PS_RWAKE, PS_RESUME, PS_RESET:
                if (t_done) r_d.st = PS_OPER;
            PS_XWAKE:
                if (sw_reset)       r_d.st = PS_RESET;
                else if (sw_resume) r_d.st = PS_RESUME;
            PS_DSUSP:
                if (sw_reset) r_d.st = PS_RESET;
                else if (line_connect) begin
                    r_d.st = PS_DCONN;
                    c_set[CAUSE_CONN] = 1'b1;
                end
            PS_DCONN:
                if (sw_reset) r_d.st = PS_RESET;
            default:
                r_d.st = PS_OPER;
        endcase
        if (r_d.st != r_q.st) t_load = 1'b1;
        t_val    = interval_of(r_d.st);
        r_d.susp = (r_d.st == PS_IDLEWAIT) || (r_d.st == PS_SUSP) ||
                   (r_d.st == PS_DSUSP)    || (r_d.st == PS_DCONN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PS_OPER, susp: 1'b0};
        else        r_q <= r_d;
    end

    pps_timer #(.MAX_VAL(MAXV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_ms),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    pps_irq #(.W(CAUSE_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (c_set),
        .clr   (irq_clr),
        .cause (irq_cause),
        .irq   (irq)
    );

    always_comb begin
        xcvr_clk_en    = 1'b1;
        traffic_block  = 1'b1;
        bus_idle_force = 1'b0;
        resume_drive   = 1'b0;
        reset_drive    = 1'b0;
        case (r_q.st)
            PS_OPER:               traffic_block  = 1'b0;
            PS_IDLEWAIT, PS_XWAKE,
            PS_DCONN:              bus_idle_force = 1'b1;
            PS_SUSP, PS_DSUSP: begin
                xcvr_clk_en    = 1'b0;
                bus_idle_force = 1'b1;
            end
            PS_RWAKE, PS_RESUME:   resume_drive   = 1'b1;
            PS_RESET:              reset_drive    = 1'b1;
            default:               traffic_block  = 1'b0;
        endcase
    end

    assign susp_bit   = r_q.susp;
    assign port_state = r_q.st;

    // R5: a K-state without wakeup enable leaves suspend untouched
    assert_kignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_SUSP && line_k && !rwake_en && !ext_wake && !sw_resume && !sw_reset)
        |=> (r_q.st == PS_SUSP && !xcvr_clk_en));
    // R8: reset wins over a simultaneous resume
    assert_rst_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == PS_SUSP || r_q.st == PS_XWAKE) && sw_reset && sw_resume)
        |=> r_q.st == PS_RESET);
    // R3: the remote-wake cause rises only after an enabled K-state
    assert_rwake_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_cause[CAUSE_RWAKE]) |-> $past(line_k && rwake_en));
    // R4: leaving a timed resume happens on a tick
    assert_resume_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_OPER && $past(r_q.st) == PS_RWAKE) |-> $past(tick_ms));
    // R10: connect-wait holds until reset
    assert_dconn_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == PS_DCONN && !sw_reset) |=> r_q.st == PS_DCONN);
endmodule

// File: tb/usb_port_pwr_tb.sv
module usb_port_pwr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_IDLE = 3, N_RES = 20, N_RST = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tick_ms = 0, sw_suspend = 0, sw_resume = 0, sw_reset = 0, rwake_en = 0;
    logic [2:0] irq_clr = 0;
    logic line_idle = 1, line_k = 0, line_connect = 0, line_disconnect = 0, ext_wake = 0;
    logic xcvr_clk_en, traffic_block, bus_idle_force, resume_drive, reset_drive, susp_bit, irq;
    logic [2:0] irq_cause;
    logic [3:0] port_state;

    int checks = 0, errors = 0;
    int m_st = 0, m_cnt = 0;
    logic [2:0] m_cause = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_port_pwr u_dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .sw_suspend(sw_suspend),
        .sw_resume(sw_resume), .sw_reset(sw_reset), .rwake_en(rwake_en), .irq_clr(irq_clr),
        .line_idle(line_idle), .line_k(line_k), .line_connect(line_connect),
        .line_disconnect(line_disconnect), .ext_wake(ext_wake), .xcvr_clk_en(xcvr_clk_en),
        .traffic_block(traffic_block), .bus_idle_force(bus_idle_force),
        .resume_drive(resume_drive), .reset_drive(reset_drive), .susp_bit(susp_bit),
        .irq(irq), .irq_cause(irq_cause), .port_state(port_state)
    );

    function automatic string req_of(input int s);
        case (s)
            0: return "R1";  1: return "R2";  2: return "R5";  3: return "R4";
            4: return "R6";  5: return "R7";  6: return "R8";  7: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int len_of(input int s);
        case (s)
            1: return N_IDLE;  3, 5: return N_RES;  6: return N_RST;
            default: return 0;
        endcase
    endfunction

    // expected {clk_en, block, idle, resume, reset, susp}
    function automatic logic [5:0] outs_of(input int s);
        case (s)
            0: return 6'b100000;  1: return 6'b111001;  2: return 6'b011001;
            3: return 6'b110100;  4: return 6'b111000;  5: return 6'b110100;
            6: return 6'b110010;  7: return 6'b011001;  default: return 6'b111001;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int ns = m_st;
        logic [2:0] s = 0;
        case (m_st)
            0: if (sw_suspend) ns = line_disconnect ? 7 : 1;
            1: if (line_idle && tick_ms && m_cnt == 1) ns = 2;
            2: if (sw_reset) ns = 6; else if (sw_resume) ns = 5;
               else if (ext_wake) begin ns = 4; s[2] = 1; end
               else if (line_k && rwake_en) begin ns = 3; s[0] = 1; end
            3, 5, 6: if (tick_ms && m_cnt == 1) ns = 0;
            4: if (sw_reset) ns = 6; else if (sw_resume) ns = 5;
            7: if (sw_reset) ns = 6; else if (line_connect) begin ns = 8; s[1] = 1; end
            default: if (sw_reset) ns = 6;
        endcase
        if (ns != m_st || (m_st == 1 && !line_idle)) m_cnt = len_of(ns);
        else if (tick_ms && m_cnt > 0) m_cnt--;
        m_cause = (m_cause & ~irq_clr) | s;
        m_st = ns;
    endtask

    task automatic compare();
        logic [5:0] e = outs_of(m_st);
        chk(req_of(m_st), int'(port_state), m_st);
        chk(req_of(m_st), int'({xcvr_clk_en, traffic_block, bus_idle_force,
                                resume_drive, reset_drive, susp_bit}), int'(e));
        chk("R11", int'(irq_cause), int'(m_cause));
        chk("R11", int'(irq), int'(|m_cause));
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare();
        tick_ms = 0; sw_suspend = 0; sw_resume = 0; sw_reset = 0; irq_clr = 0; ext_wake = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick_ms = 1; cyc(); cyc(); end
    endtask

    task automatic go_susp();
        line_idle = 1; sw_suspend = 1; cyc(); ticks(N_IDLE);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk("R1", int'(port_state), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", int'({xcvr_clk_en, traffic_block, bus_idle_force, susp_bit, irq}), 5'b10000);
        compare();

        // R2: idle-wait with a restart of the count
        sw_suspend = 1; cyc();
        chk("R2", int'(port_state), 1);
        chk("R2", int'(xcvr_clk_en), 1);
        ticks(2); line_idle = 0; cyc(); line_idle = 1;
        ticks(2);
        chk("R2", int'(port_state), 1);
        ticks(1);
        chk("R2", int'(port_state), 2);
        chk("R2", int'(xcvr_clk_en), 0);

        // R5: ignored K-state
        rwake_en = 0; line_k = 1;
        repeat (5) cyc();
        chk("R5", int'(port_state), 2);
        chk("R5", int'(irq), 0);
        line_k = 0;

        // R8: reset beats resume
        sw_reset = 1; sw_resume = 1; cyc();
        chk("R8", int'(port_state), 6);
        ticks(N_RST - 1);
        chk("R8", int'(port_state), 6);
        ticks(1);
        chk("R8", int'(port_state), 0);

        // R3 and R4: remote wake with a tick on the entry edge
        go_susp();
        rwake_en = 1; line_k = 1; tick_ms = 1; cyc(); line_k = 0;
        chk("R3", int'(port_state), 3);
        chk("R3", int'(irq_cause), 3'b001);
        chk("R3", int'(susp_bit), 0);
        ticks(N_RES - 1);
        chk("R4", int'(port_state), 3);
        ticks(1);
        chk("R4", int'(port_state), 0);
        irq_clr = 3'b001; cyc();
        chk("R11", int'(irq), 0);

        // R6 and R7: external wake then software resume
        go_susp();
        ext_wake = 1; cyc();
        chk("R6", int'(port_state), 4);
        chk("R6", int'({xcvr_clk_en, susp_bit, irq_cause}), 5'b10100);
        sw_resume = 1; cyc();
        chk("R7", int'(port_state), 5);
        ticks(N_RES);
        chk("R7", int'(port_state), 0);

        // R9 and R10: disconnect suspend, connect, hold, reset
        line_disconnect = 1; sw_suspend = 1; irq_clr = 3'b111; cyc();
        chk("R9", int'(port_state), 7);
        chk("R9", int'(xcvr_clk_en), 0);
        line_connect = 1; cyc(); line_connect = 0;
        chk("R10", int'(port_state), 8);
        chk("R10", int'(irq_cause), 3'b010);
        sw_resume = 1; cyc(); cyc();
        chk("R10", int'(port_state), 8);
        // R11: set and clear of the same bit in one cycle is tested in the random phase
        sw_reset = 1; cyc();
        chk("R10", int'(port_state), 6);
        ticks(N_RST);
        line_disconnect = 0;

        // random phase against the model
        for (int n = 0; n < 20000; n++) begin
            tick_ms    = ($urandom % 4) == 0;
            sw_suspend = ($urandom % 40) == 0;
            sw_resume  = ($urandom % 70) == 0;
            sw_reset   = ($urandom % 90) == 0;
            ext_wake   = ($urandom % 60) == 0;
            irq_clr    = (($urandom % 10) == 0) ? 3'($urandom) : 3'b000;
            line_idle  = ($urandom % 12) != 0;
            line_k     = ($urandom % 8) == 0;
            line_connect = ($urandom % 30) == 0;
            if (($urandom % 100) == 0) line_disconnect = ~line_disconnect;
            if (($urandom % 50) == 0)  rwake_en = ~rwake_en;
            cyc();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule